// File: doc/BRIEF.md
# Transmit Descriptor Ring Poller

This block sits at the front of a packet transmitter's DMA path. Software writes transmit buffer descriptors into a small circular ring and then strobes a "descriptors active" control bit. The poller walks the ring from its saved position and reads each descriptor. For every descriptor marked ready it streams the referenced buffer, one byte per cycle, into a downstream byte FIFO. Once a buffer has been fully consumed, the poller writes the descriptor back with its ready flag cleared, which returns the buffer to software.

A frame may occupy several consecutive descriptors; the final one carries an end-of-frame marker. The poller treats two situations differently:

- **Not-ready descriptor between frames.** It reads the descriptor a second time before it stops polling and drops the active bit.
- **Not-ready descriptor inside a frame.** This is an underrun. The poller pulses an error, abandons the remainder of the frame, and resumes at the descriptor that follows the frame's end marker.

Descriptor layout, 64 bits: length in bits [15:0], ready in bit 16, wrap in bit 17, end-of-frame in bit 18, buffer base byte address in bits [63:32]. Bits [31:19] are unused.

Top module: `txr_ring_poller`

## Requirements
- R1: Only a descriptor with bit 16 (ready) set is transmitted. Its buffer is sent as the bytes at addresses base+0 through base+len-1, in increasing order, where base is bits [63:32] and len is bits [15:0]. Each byte is taken from `buf_data` while `buf_addr` holds that address. A ready descriptor that lies beyond a stopping point is not sent.
- R2: No byte is pushed in a cycle where `fifo_full` is high. Backpressure does not reorder, drop or duplicate any byte.
- R3: `fifo_last` is high together with `fifo_push` only on the final byte of a descriptor that has bit 18 (end-of-frame) set. The bytes of a frame spread over several descriptors arrive contiguously.
- R4: When a descriptor's buffer has been consumed, its ring entry reads back with bit 16 cleared and every other field unchanged.
- R5: When a not-ready descriptor is found outside a frame, it is fetched exactly twice at the same ring index. The poller then stops and `active` falls.
- R6: A `kick` while `active` is low raises `active` and starts polling at the entry after the last one processed, not at entry 0.
- R7: A `kick` while `active` is high has no effect. The fetch sequence and the streamed bytes are the same as without it.
- R8: After a descriptor with bit 17 (wrap) set, the next fetch is at index 0. After entry DEPTH-1, the next fetch is at index 0 whether or not wrap is set.
- R9: A not-ready descriptor found after a frame has started raises `underrun` for exactly one cycle. The bytes already sent carry no `fifo_last`. Descriptors are then skipped, each written back with ready cleared, up to and including the one with the end-of-frame bit, and polling continues at the next entry.
- R10: `fifo_push` is only ever high while `active` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; clears the ring and the saved position |
| kick | input | 1 | Write strobe setting the descriptors-active bit |
| desc_wr_en | input | 1 | Host write enable into the ring |
| desc_wr_idx | input | IW | Host write ring index |
| desc_wr_data | input | 64 | Host descriptor write data |
| desc_rd_idx | input | IW | Host read ring index |
| desc_rd_data | output | 64 | Descriptor at `desc_rd_idx` (combinational) |
| active | output | 1 | Descriptors-active bit |
| poll_req | output | 1 | A descriptor fetch is issued this cycle |
| poll_idx | output | IW | Ring index being fetched or processed |
| buf_addr | output | 32 | Buffer byte address being read |
| buf_data | input | 8 | Buffer byte at `buf_addr`, same cycle |
| fifo_full | input | 1 | Downstream FIFO cannot accept a byte |
| fifo_push | output | 1 | Byte written to the FIFO this cycle |
| fifo_data | output | 8 | Byte being pushed |
| fifo_last | output | 1 | Pushed byte ends a frame |
| underrun | output | 1 | One-cycle pulse on a broken frame |

## Verification
A wrong saved ring position shows at the ports on the first fetch after a kick: `poll_idx` points at the wrong entry, and the first pushed byte comes from the wrong buffer. A lost in-frame flag changes the classification of the next not-ready descriptor. Instead of a single-cycle `underrun` followed by a skip, the bench would see two fetches at the same index and `active` falling within about four cycles. A broken byte offset or a missing write-back appears as a mismatched byte or a still-set ready bit when the ring is read back after polling stops.

// File: rtl/txr_pkg.sv
package txr_pkg;

  localparam int DESC_W = 64;

  // Ring entry, most significant field first
  typedef struct packed {
    logic [31:0] base;
    logic [12:0] spare;
    logic        eof;
    logic        wrap;
    logic        ready;
    logic [15:0] len;
  } txd_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_CHECK,
    ST_STREAM,
    ST_WBACK
  } txr_state_e;

  // Entry handed back to software
  function automatic txd_t txd_retire(txd_t d);
    txd_t r;
    r       = d;
    r.ready = 1'b0;
    return r;
  endfunction

  // Byte address within a buffer
  function automatic logic [31:0] txd_byte_addr(logic [31:0] base, logic [15:0] off);
    return base + 32'(off);
  endfunction

  // True when the offset names the final byte of the buffer
  function automatic logic txd_final_byte(logic [15:0] off, logic [15:0] len);
    return (off == (len - 16'd1));
  endfunction

endpackage

// File: rtl/txr_desc_ram.sv
module txr_desc_ram #(
  parameter int DEPTH = 8,
  parameter int IW    = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        host_we,
  input  logic [IW-1:0]               host_widx,
  input  logic [txr_pkg::DESC_W-1:0]  host_wdata,
  input  logic [IW-1:0]               host_ridx,
  output logic [txr_pkg::DESC_W-1:0]  host_rdata,
  input  logic                        eng_re,
  input  logic [IW-1:0]               eng_ridx,
  output logic [txr_pkg::DESC_W-1:0]  eng_rdata,
  input  logic                        eng_we,
  input  logic [IW-1:0]               eng_widx,
  input  logic [txr_pkg::DESC_W-1:0]  eng_wdata
);

  logic [txr_pkg::DESC_W-1:0] mem [DEPTH];

  // Host write is applied last so software re-arming an entry wins a collision
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (eng_we)  mem[eng_widx]  <= eng_wdata;
      if (host_we) mem[host_widx] <= host_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      eng_rdata <= '0;
    else if (eng_re) eng_rdata <= mem[eng_ridx];
  end

  assign host_rdata = mem[host_ridx];

endmodule

// File: rtl/txr_active_ctl.sv
module txr_active_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  input  logic stop,
  output logic active,
  output logic start
);

  // Only a 0-to-1 change of the bit starts polling
  assign start = kick & ~active;

  always_ff @(posedge clk) begin
    if (!rst_n)     active <= 1'b0;
    else if (start) active <= 1'b1;
    else if (stop)  active <= 1'b0;
  end

endmodule

// File: rtl/txr_byte_streamer.sv
module txr_byte_streamer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic        run,
  input  logic [31:0] base,
  input  logic [15:0] len,
  input  logic        fifo_full,
  output logic [31:0] addr,
  output logic        push,
  output logic        done
);
  import txr_pkg::*;

  logic [15:0] off;

  assign push = run & ~fifo_full;
  assign done = push & txd_final_byte(off, len);
  assign addr = txd_byte_addr(base, off);

  always_ff @(posedge clk) begin
    if (!rst_n)     off <= '0;
    else if (load)  off <= '0;
    else if (push)  off <= off + 16'd1;
  end

endmodule

// File: rtl/txr_ring_poller.sv
module txr_ring_poller #(
  parameter  int DEPTH = 8,
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kick,
  input  logic          desc_wr_en,
  input  logic [IW-1:0] desc_wr_idx,
  input  logic [63:0]   desc_wr_data,
  input  logic [IW-1:0] desc_rd_idx,
  output logic [63:0]   desc_rd_data,
  output logic          active,
  output logic          poll_req,
  output logic [IW-1:0] poll_idx,
  output logic [31:0]   buf_addr,
  input  logic [7:0]    buf_data,
  input  logic          fifo_full,
  output logic          fifo_push,
  output logic [7:0]    fifo_data,
  output logic          fifo_last,
  output logic          underrun
);
  import txr_pkg::*;

  localparam logic [IW-1:0] LAST_IDX = IW'(DEPTH - 1);

  // Successor index on the ring
  function automatic logic [IW-1:0] ring_next(logic [IW-1:0] idx, logic wrap);
    return (wrap || idx == LAST_IDX) ? '0 : idx + 1'b1;
  endfunction

  txr_state_e    state;
  logic [IW-1:0] cur_idx;
  txd_t          cur_d;
  logic          retry_q;
  logic          in_frame;
  logic          skip_q;
  logic [IW-1:0] skip_cnt;

  logic [DESC_W-1:0] eng_rdata;
  txd_t              rd_d;
  logic              start;

  // Named internal events
  logic evt_take;
  logic evt_underrun;
  logic evt_retry;
  logic evt_giveup;
  logic evt_skip;
  logic evt_wback;
  logic evt_done;

  assign rd_d         = txd_t'(eng_rdata);
  assign evt_skip     = (state == ST_CHECK) &&  skip_q;
  assign evt_take     = (state == ST_CHECK) && !skip_q &&  rd_d.ready;
  assign evt_underrun = (state == ST_CHECK) && !skip_q && !rd_d.ready &&  in_frame;
  assign evt_retry    = (state == ST_CHECK) && !skip_q && !rd_d.ready && !in_frame && !retry_q;
  assign evt_giveup   = (state == ST_CHECK) && !skip_q && !rd_d.ready && !in_frame &&  retry_q;
  assign evt_wback    = (state == ST_WBACK);

  assign poll_req = (state == ST_FETCH);
  assign poll_idx = cur_idx;
  assign underrun = evt_underrun;

  txr_active_ctl u_active (
    .clk    (clk),
    .rst_n  (rst_n),
    .kick   (kick),
    .stop   (evt_giveup),
    .active (active),
    .start  (start)
  );

  txr_desc_ram #(.DEPTH(DEPTH), .IW(IW)) u_ram (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (desc_wr_en),
    .host_widx  (desc_wr_idx),
    .host_wdata (desc_wr_data),
    .host_ridx  (desc_rd_idx),
    .host_rdata (desc_rd_data),
    .eng_re     (poll_req),
    .eng_ridx   (cur_idx),
    .eng_rdata  (eng_rdata),
    .eng_we     (evt_wback),
    .eng_widx   (cur_idx),
    .eng_wdata  (DESC_W'(txd_retire(cur_d)))
  );

  txr_byte_streamer u_stream (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (evt_take),
    .run       (state == ST_STREAM),
    .base      (cur_d.base),
    .len       (cur_d.len),
    .fifo_full (fifo_full),
    .addr      (buf_addr),
    .push      (fifo_push),
    .done      (evt_done)
  );

  assign fifo_data = buf_data;
  assign fifo_last = evt_done & cur_d.eof;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur_idx  <= '0;
      cur_d    <= '0;
      retry_q  <= 1'b0;
      in_frame <= 1'b0;
      skip_q   <= 1'b0;
      skip_cnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) state <= ST_FETCH;
        end
        ST_FETCH: begin
          state <= ST_CHECK;
        end
        ST_CHECK: begin
          if (evt_skip) begin
            cur_d <= rd_d;
            state <= ST_WBACK;
          end else if (evt_take) begin
            cur_d    <= rd_d;
            retry_q  <= 1'b0;
            in_frame <= 1'b1;
            state    <= (rd_d.len == 16'd0) ? ST_WBACK : ST_STREAM;
          end else if (evt_underrun) begin
            cur_d    <= rd_d;
            in_frame <= 1'b0;
            skip_q   <= 1'b1;
            skip_cnt <= '0;
            state    <= ST_WBACK;
          end else if (evt_retry) begin
            retry_q <= 1'b1;
            state   <= ST_FETCH;
          end else begin
            retry_q <= 1'b0;
            state   <= ST_IDLE;
          end
        end
        ST_STREAM: begin
          if (evt_done) state <= ST_WBACK;
        end
        ST_WBACK: begin
          cur_idx <= ring_next(cur_idx, cur_d.wrap);
          if (skip_q) begin
            skip_cnt <= skip_cnt + 1'b1;
            if (cur_d.eof || skip_cnt == LAST_IDX) skip_q <= 1'b0;
          end else if (cur_d.eof) begin
            in_frame <= 1'b0;
          end
          state <= ST_FETCH;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/txr_ring_checker.sv
module txr_ring_checker #(
  parameter  int DEPTH = 8,
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          active,
  input logic          poll_req,
  input logic [IW-1:0] poll_idx,
  input logic          fifo_full,
  input logic          fifo_push,
  input logic          fifo_last,
  input logic          underrun
);

  assert_hold_on_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !fifo_push);

  assert_last_is_push_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_last |-> fifo_push);

  assert_stop_after_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> $past(poll_req, 2));

  assert_rise_fetches_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> poll_req);

  assert_fetch_idx_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    poll_req |=> $stable(poll_idx));

  assert_underrun_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !underrun);

  assert_underrun_no_push_R9: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> !fifo_push);

  assert_push_needs_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> active);

endmodule

bind txr_ring_poller txr_ring_checker #(.DEPTH(DEPTH)) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .active    (active),
  .poll_req  (poll_req),
  .poll_idx  (poll_idx),
  .fifo_full (fifo_full),
  .fifo_push (fifo_push),
  .fifo_last (fifo_last),
  .underrun  (underrun)
);

// File: tb/txr_ring_poller_bench.sv
module txr_ring_poller_bench;

  localparam int DEPTH = 8;
  localparam int IW    = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          kick = 1'b0;
  logic          wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [63:0]   wr_data = '0;
  logic [IW-1:0] rd_idx = '0;
  logic [63:0]   rd_data;
  logic          active, poll_req, fifo_push, fifo_last, underrun;
  logic [IW-1:0] poll_idx;
  logic [31:0]   buf_addr;
  logic [7:0]    buf_data, fifo_data;
  logic          bp_en = 1'b0;
  logic [7:0]    lf = 8'h5B;
  logic          fifo_full;

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0] cap_d [512];
  logic       cap_l [512];
  int cap_n, under_n, under_len, under_max, poll_n, full_push;
  logic [IW-1:0] poll_last;
  logic [IW-1:0] poll_seen [16];

  always #5 clk = ~clk;

  function automatic logic [7:0] bexp(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [63:0] mk(input logic [31:0] base, input logic [15:0] len,
                                     input logic rdy, input logic wrap, input logic eof);
    return {base, 13'd0, eof, wrap, rdy, len};
  endfunction

  assign buf_data  = bexp(buf_addr);
  assign fifo_full = bp_en & lf[0];

  txr_ring_poller u_txr_ring_poller (
    .clk(clk), .rst_n(rst_n), .kick(kick),
    .desc_wr_en(wr_en), .desc_wr_idx(wr_idx), .desc_wr_data(wr_data),
    .desc_rd_idx(rd_idx), .desc_rd_data(rd_data),
    .active(active), .poll_req(poll_req), .poll_idx(poll_idx),
    .buf_addr(buf_addr), .buf_data(buf_data), .fifo_full(fifo_full),
    .fifo_push(fifo_push), .fifo_data(fifo_data), .fifo_last(fifo_last),
    .underrun(underrun)
  );

  always @(negedge clk) if (bp_en) lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};

  always @(posedge clk) cyc <= cyc + 1;

  // Output monitor, sampled after the falling edge has settled
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (fifo_push && cap_n < 512) begin
        cap_d[cap_n] = fifo_data;
        cap_l[cap_n] = fifo_last;
        cap_n++;
      end
      if (fifo_push && fifo_full) full_push++;
      if (poll_req) begin
        if (poll_n < 16) poll_seen[poll_n] = poll_idx;
        poll_n++;
        poll_last = poll_idx;
      end
      if (underrun) begin
        under_len++;
        if (under_len == 1) under_n++;
        if (under_len > under_max) under_max = under_len;
      end else begin
        under_len = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic clear_caps();
    cap_n = 0; under_n = 0; under_len = 0; under_max = 0;
    poll_n = 0; full_push = 0; poll_last = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; kick = 1'b0; wr_en = 1'b0; bp_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    clear_caps();
  endtask

  task automatic put(input int idx, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic get(input int idx, output logic [63:0] d);
    rd_idx = IW'(idx);
    #1;
    d = rd_data;
  endtask

  task automatic pulse_kick();
    @(negedge clk); kick = 1'b1;
    @(negedge clk); kick = 1'b0;
  endtask

  task automatic wait_stop(input string tag);
    int n = 0;
    while (active && n < 5000) begin
      @(negedge clk);
      n++;
    end
    repeat (2) @(negedge clk);
    chk(!active, tag, 32'(active), 0);
  endtask

  task automatic check_bytes(input int pos, input logic [31:0] base, input int len, input string tag);
    for (int i = 0; i < len; i++)
      chk(cap_d[pos+i] == bexp(base + 32'(i)), tag, 32'(cap_d[pos+i]), 32'(bexp(base + 32'(i))));
  endtask

  task automatic t_reset();
    logic [63:0] d;
    do_reset();
    chk(!active && !fifo_push && !underrun && !poll_req, "R6 reset outputs idle",
        {28'd0, active, fifo_push, underrun, poll_req}, 0);
    get(0, d);
    chk(d == 64'd0, "R4 reset ring cleared", d[31:0], 0);
  endtask

  task automatic t_single();
    logic [63:0] d;
    int lasts = 0;
    do_reset();
    put(0, mk(32'h100, 16'd5, 1, 0, 1));
    put(2, mk(32'h800, 16'd4, 1, 0, 1));
    pulse_kick();
    wait_stop("R5 stop after single frame");
    chk(cap_n == 5, "R1 single frame byte count", cap_n, 5);
    check_bytes(0, 32'h100, 5, "R1 single frame bytes");
    for (int i = 0; i < cap_n; i++) if (cap_l[i]) lasts++;
    chk(lasts == 1 && cap_l[4], "R3 single frame end marker", lasts, 1);
    get(0, d);
    chk(d == mk(32'h100, 16'd5, 0, 0, 1), "R4 write-back clears ready only", d[31:0],
        32'(mk(32'h100, 16'd5, 0, 0, 1)));
    get(2, d);
    chk(d[16] == 1'b1, "R1 entry past stop untouched", 32'(d[16]), 1);
  endtask

  task automatic t_multi();
    logic [63:0] d;
    int lasts = 0;
    do_reset();
    put(0, mk(32'h200, 16'd3, 1, 0, 0));
    put(1, mk(32'h340, 16'd2, 1, 0, 0));
    put(2, mk(32'h4F0, 16'd4, 1, 0, 1));
    pulse_kick();
    wait_stop("R5 stop after chained frame");
    chk(cap_n == 9, "R3 chained frame byte count", cap_n, 9);
    check_bytes(0, 32'h200, 3, "R3 chained part 0");
    check_bytes(3, 32'h340, 2, "R3 chained part 1");
    check_bytes(5, 32'h4F0, 4, "R3 chained part 2");
    for (int i = 0; i < cap_n; i++) if (cap_l[i]) lasts++;
    chk(lasts == 1 && cap_l[8], "R3 chained frame single marker", lasts, 1);
    for (int i = 0; i < 3; i++) begin
      get(i, d);
      chk(d[16] == 1'b0, "R4 chained entries retired", 32'(d[16]), 0);
    end
  endtask

  task automatic t_backpressure();
    do_reset();
    put(0, mk(32'h1F8, 16'd24, 1, 0, 1));
    bp_en = 1'b1;
    pulse_kick();
    wait_stop("R2 stop under backpressure");
    bp_en = 1'b0;
    chk(cap_n == 24, "R2 byte count under backpressure", cap_n, 24);
    check_bytes(0, 32'h1F8, 24, "R2 bytes under backpressure");
    chk(full_push == 0, "R2 no push while full", full_push, 0);
  endtask

  task automatic t_poll_twice();
    do_reset();
    pulse_kick();
    wait_stop("R5 stop on empty ring");
    chk(poll_n == 2, "R5 two fetches of not-ready entry", poll_n, 2);
    chk(poll_seen[0] == 0 && poll_seen[1] == 0, "R5 both fetches same index",
        32'(poll_seen[1]), 0);
    chk(cap_n == 0, "R10 nothing pushed on empty ring", cap_n, 0);
  endtask

  task automatic t_resume();
    do_reset();
    put(0, mk(32'h300, 16'd2, 1, 0, 1));
    pulse_kick();
    wait_stop("R6 first pass stops");
    clear_caps();
    put(0, mk(32'h600, 16'd3, 1, 0, 1));
    put(1, mk(32'h700, 16'd2, 1, 0, 1));
    pulse_kick();
    wait_stop("R6 second pass stops");
    chk(poll_seen[0] == 1, "R6 resume fetches saved index", 32'(poll_seen[0]), 1);
    chk(cap_n == 2, "R6 only entry after saved point sent", cap_n, 2);
    check_bytes(0, 32'h700, 2, "R6 resumed bytes");
  endtask

  task automatic t_kick_high();
    do_reset();
    put(0, mk(32'hA00, 16'd40, 1, 0, 1));
    pulse_kick();
    repeat (10) @(negedge clk);
    pulse_kick();
    chk(active == 1'b1, "R7 active held on redundant kick", 32'(active), 1);
    wait_stop("R7 stop after frame");
    chk(cap_n == 40, "R7 byte count unchanged", cap_n, 40);
    check_bytes(0, 32'hA00, 40, "R7 bytes unchanged");
    chk(poll_n == 3, "R7 fetch count unchanged", poll_n, 3);
  endtask

  task automatic t_wrap();
    logic [63:0] d;
    do_reset();
    put(0, mk(32'hB00, 16'd1, 1, 0, 1));
    put(1, mk(32'hB40, 16'd1, 1, 1, 1));
    put(2, mk(32'hB80, 16'd1, 1, 0, 1));
    pulse_kick();
    wait_stop("R8 stop after wrap");
    chk(cap_n == 2, "R8 wrap byte count", cap_n, 2);
    chk(poll_last == 0, "R8 fetch after wrap at index 0", 32'(poll_last), 0);
    get(2, d);
    chk(d[16] == 1'b1, "R8 entry after wrap not used", 32'(d[16]), 1);
    // ring end without wrap bit
    do_reset();
    for (int i = 0; i < DEPTH; i++) put(i, mk(32'hC00 + 32'(i*16), 16'd1, 1, 0, 1));
    pulse_kick();
    wait_stop("R8 stop after full ring");
    chk(cap_n == DEPTH, "R8 full ring byte count", cap_n, DEPTH);
    chk(poll_last == 0, "R8 natural wrap to index 0", 32'(poll_last), 0);
  endtask

  task automatic t_underrun();
    logic [63:0] d;
    do_reset();
    put(0, mk(32'hD00, 16'd3, 1, 0, 0));
    put(1, mk(32'hD40, 16'd2, 0, 0, 0));
    put(2, mk(32'hD80, 16'd2, 1, 0, 1));
    put(3, mk(32'hE00, 16'd2, 1, 0, 1));
    pulse_kick();
    wait_stop("R9 stop after recovery");
    chk(under_n == 1, "R9 one underrun event", under_n, 1);
    chk(under_max == 1, "R9 underrun one cycle wide", under_max, 1);
    chk(cap_n == 5, "R9 byte count with skip", cap_n, 5);
    check_bytes(0, 32'hD00, 3, "R9 bytes before break");
    chk(!cap_l[0] && !cap_l[1] && !cap_l[2], "R9 broken frame has no marker",
        {29'd0, cap_l[0], cap_l[1], cap_l[2]}, 0);
    check_bytes(3, 32'hE00, 2, "R9 next frame after skip");
    chk(cap_l[4], "R9 next frame marker", 32'(cap_l[4]), 1);
    get(2, d);
    chk(d[16] == 1'b0, "R9 skipped entry retired", 32'(d[16]), 0);
  endtask

  initial begin
    t_reset();
    t_single();
    t_multi();
    t_backpressure();
    t_poll_twice();
    t_resume();
    t_kick_high();
    t_wrap();
    t_underrun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected<150000", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule